// File: doc/BRIEF.md
# I2C Master Transaction Sequencer

This block is the control state machine behind a register-driven I2C master. The host issues single-cycle strobes: start, stop, data write, data read, and write-one-to-clear strobes for individual flags. The block decides what each strobe means in the current phase of a transfer and keeps the status flags that software polls. It also issues one-cycle commands to a separate bus engine. That engine generates the clock and drives the pins, and it reports back the acknowledge result of the byte it is handed.

After a start, the first data write is the address byte. Bit 0 of that byte is the direction, 1 for read, and bits 7:1 are the target address. The phase then follows the acknowledge and the direction: sending, receiving, or the NACK phase. A stop request is not always executed at once. While receiving, it waits until the host reads the last byte. After a NACK, it waits until the host clears the NACK flag. Dropping the module enable wipes every flag and returns the sequencer to idle.

Top module: `i2c_mst_seq`

## Requirements
- R1: After reset every flag output is 0 and no command pulse is issued.
- R2: A start succeeds when bus_busy_i is 0, or when the sequencer is not in its idle phase (a repeated start). Success sets mode, xmit, data_rdy, busy and bb, and also sets txe when fifo_en_i is 1. The phase returns to idle.
- R3: A start made while bus_busy_i is 1 in the idle phase fails. It clears mode and busy, sets ber and bb, and leaves the phase at idle.
- R4: In master mode in the idle phase, a data write is the address byte. It pulses cmd_addr_o with the byte on cmd_byte_o. On ack_i=1 it clears nack and enters receiving with xmit cleared (bit 0 = 1) or sending with xmit set (bit 0 = 0). It then sets data_rdy, and also sets txe when sending with fifo_en_i=1.
- R5: An address write with ack_i=0 clears data_rdy, sets nack, sets or clears xmit by bit 0, and enters the NACK phase.
- R6: With stall_en_i=1, an acknowledged address sets stall instead of data_rdy.
- R7: A stop in master mode in the idle or sending phase executes at once. It pulses cmd_end_o, clears mode, xmit, data_rdy, ber, nack, stall, busy and bb, sets eob, and returns to idle.
- R8: A stop while receiving is deferred. The deferred stop executes on a data read when fifo_en_i=0 or rx_cnt_i<=1. A read with fifo_en_i=1 and rx_cnt_i>1 leaves it pending.
- R9: A stop in the NACK phase is deferred until nack_clr_i. That strobe clears nack and then executes the stop.
- R10: Data writes are ignored outside master mode and in any phase other than idle or sending. Stop is ignored outside master mode.
- R11: While en_i is 0, every flag including eob and txe is cleared, the phase is idle, and no command is issued.
- R12: ber_clr_i, stall_clr_i, eob_clr_i and nack_clr_i each clear their own flag.
- R13: A data write while sending pulses cmd_tx_o with the byte. On ack_i=1 it sets data_rdy, and also txe with fifo_en_i=1. On ack_i=0 it clears data_rdy, sets nack and enters the NACK phase.
- R14: A data read while receiving pulses cmd_rx_o and sets data_rdy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Module enable |
| fifo_en_i | input | 1 | FIFO mode selected |
| stall_en_i | input | 1 | Stall after address acknowledge |
| start_i | input | 1 | Start request strobe |
| stop_i | input | 1 | Stop request strobe |
| wr_i | input | 1 | Data write strobe |
| wr_data_i | input | DATA_W | Written byte |
| rd_i | input | 1 | Data read strobe |
| rx_cnt_i | input | CNT_W | Bytes held in the receive FIFO |
| ack_i | input | 1 | Acknowledge result for the byte written this cycle |
| bus_busy_i | input | 1 | Bus is in use |
| ber_clr_i | input | 1 | Clear bus error |
| nack_clr_i | input | 1 | Clear NACK flag |
| stall_clr_i | input | 1 | Clear stall flag |
| eob_clr_i | input | 1 | Clear end-of-busy flag |
| mode_o | output | 1 | Master mode |
| xmit_o | output | 1 | Transmit direction |
| data_rdy_o | output | 1 | Data register ready |
| ber_o | output | 1 | Bus error |
| nack_o | output | 1 | Negative acknowledge seen |
| stall_o | output | 1 | Stalled after address |
| txe_o | output | 1 | TX FIFO empty |
| busy_o | output | 1 | Master busy |
| bb_o | output | 1 | Bus-busy bit |
| eob_o | output | 1 | End of busy |
| cmd_addr_o | output | 1 | Send-address command |
| cmd_tx_o | output | 1 | Send-byte command |
| cmd_rx_o | output | 1 | Receive-byte command |
| cmd_end_o | output | 1 | End-transfer command |
| cmd_byte_o | output | DATA_W | Byte for cmd_addr_o or cmd_tx_o |

## Verification
The bench targets the deferred stops. A design that ends a receive on the stop strobe itself, or on a FIFO read with several bytes still buffered, would pulse cmd_end_o too early. A design that ignores nack_clr_i in the pending-stop phase would hang in master mode. The start-availability rule is checked from both sides: a repeated start with the bus busy must succeed, and a start from idle with the bus busy must raise ber. Ignored data writes are checked at the ports, in the NACK phase, while receiving and outside master mode, where a faulty design would emit a stray cmd_tx_o or cmd_addr_o. A reference model computes the expected flags across a long random mix of strobes, so any flag left set after a stop or a disable shows up.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SEND, ST_RECV, ST_NACK, ST_STOP_RX, ST_STOP_NK
  } seq_st_e;

  localparam int NFLAG   = 10;
  localparam int F_MODE  = 0;
  localparam int F_XMIT  = 1;
  localparam int F_RDY   = 2;
  localparam int F_BER   = 3;
  localparam int F_NACK  = 4;
  localparam int F_STALL = 5;
  localparam int F_TXE   = 6;
  localparam int F_BUSY  = 7;
  localparam int F_BB    = 8;
  localparam int F_EOB   = 9;
endpackage

// File: rtl/i2c_seq_flags.sv
module i2c_seq_flags #(
  parameter int N = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q;
    // clear wins over set
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (clr_i[i]) q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;
    end
    assign q_o[i] = q;
  end
endmodule

// File: rtl/i2c_seq_cmd.sv
module i2c_seq_cmd #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_i,
  input  logic              tx_i,
  input  logic              rx_i,
  input  logic              end_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic              addr_o,
  output logic              tx_o,
  output logic              rx_o,
  output logic              end_o,
  output logic [DATA_W-1:0] byte_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= 1'b0;
      tx_o   <= 1'b0;
      rx_o   <= 1'b0;
      end_o  <= 1'b0;
      byte_o <= '0;
    end else begin
      addr_o <= addr_i;
      tx_o   <= tx_i;
      rx_o   <= rx_i;
      end_o  <= end_i;
      if (addr_i || tx_i) byte_o <= byte_i;
    end
  end
endmodule

// File: rtl/i2c_seq_ctl.sv
module i2c_seq_ctl
  import i2c_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              fifo_en_i,
  input  logic              stall_en_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_i,
  input  logic [CNT_W-1:0]  rx_cnt_i,
  input  logic              ack_i,
  input  logic              bus_busy_i,
  input  logic              ber_clr_i,
  input  logic              nack_clr_i,
  input  logic              stall_clr_i,
  input  logic              eob_clr_i,
  input  logic              mode_i,
  output logic [NFLAG-1:0]  set_o,
  output logic [NFLAG-1:0]  clr_o,
  output logic              c_addr_o,
  output logic              c_tx_o,
  output logic              c_rx_o,
  output logic              c_end_o
);
  localparam logic [NFLAG-1:0] END_CLR = NFLAG'((1 << F_MODE) | (1 << F_XMIT) |
    (1 << F_RDY) | (1 << F_BER) | (1 << F_NACK) | (1 << F_STALL) |
    (1 << F_BUSY) | (1 << F_BB));

  seq_st_e st_q, st_n;
  logic    exec_stop;
  logic    is_read;

  assign is_read = wr_data_i[0];

  always_comb begin
    st_n      = st_q;
    set_o     = '0;
    clr_o     = '0;
    c_addr_o  = 1'b0;
    c_tx_o    = 1'b0;
    c_rx_o    = 1'b0;
    exec_stop = 1'b0;
    if (!en_i) begin
      clr_o = '1;
      st_n  = ST_IDLE;
    end else begin
      if (start_i) begin
        if (!bus_busy_i || st_q != ST_IDLE) begin
          set_o[F_MODE] = 1'b1;
          set_o[F_XMIT] = 1'b1;
          set_o[F_RDY]  = 1'b1;
          set_o[F_BUSY] = 1'b1;
          set_o[F_TXE]  = fifo_en_i;
        end else begin
          clr_o[F_MODE] = 1'b1;
          clr_o[F_BUSY] = 1'b1;
          set_o[F_BER]  = 1'b1;
        end
        set_o[F_BB] = 1'b1;
        st_n        = ST_IDLE;
      end else if (stop_i && mode_i) begin
        unique case (st_q)
          ST_RECV:                st_n = ST_STOP_RX;
          ST_NACK:                st_n = ST_STOP_NK;
          ST_STOP_RX, ST_STOP_NK: st_n = st_q;
          default:                exec_stop = 1'b1;
        endcase
      end else if (wr_i && mode_i && st_q == ST_IDLE) begin
        c_addr_o = 1'b1;
        if (is_read) clr_o[F_XMIT] = 1'b1;
        else         set_o[F_XMIT] = 1'b1;
        if (!ack_i) begin
          clr_o[F_RDY]  = 1'b1;
          set_o[F_NACK] = 1'b1;
          st_n          = ST_NACK;
        end else begin
          clr_o[F_NACK] = 1'b1;
          st_n          = is_read ? ST_RECV : ST_SEND;
          if (stall_en_i) set_o[F_STALL] = 1'b1;
          else            set_o[F_RDY]   = 1'b1;
          set_o[F_TXE] = fifo_en_i && !is_read;
        end
      end else if (wr_i && mode_i && st_q == ST_SEND) begin
        c_tx_o = 1'b1;
        if (!ack_i) begin
          clr_o[F_RDY]  = 1'b1;
          set_o[F_NACK] = 1'b1;
          st_n          = ST_NACK;
        end else begin
          set_o[F_RDY] = 1'b1;
          set_o[F_TXE] = fifo_en_i;
        end
      end else if (rd_i && st_q == ST_RECV) begin
        c_rx_o       = 1'b1;
        set_o[F_RDY] = 1'b1;
      end else if (rd_i && st_q == ST_STOP_RX &&
                   (!fifo_en_i || rx_cnt_i <= CNT_W'(1))) begin
        exec_stop = 1'b1;
      end else if (nack_clr_i && st_q == ST_STOP_NK) begin
        exec_stop = 1'b1;
      end
      if (exec_stop) begin
        clr_o        = clr_o | END_CLR;
        set_o[F_EOB] = 1'b1;
        st_n         = ST_IDLE;
      end
      if (ber_clr_i)   clr_o[F_BER]   = 1'b1;
      if (nack_clr_i)  clr_o[F_NACK]  = 1'b1;
      if (stall_clr_i) clr_o[F_STALL] = 1'b1;
      if (eob_clr_i)   clr_o[F_EOB]   = 1'b1;
    end
  end

  assign c_end_o = exec_stop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_n;
  end

  // R8: a pending receive stop only exists while still master
  a_r8_pending_rx_master: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_STOP_RX |-> mode_i);
endmodule

// File: rtl/i2c_mst_seq.sv
module i2c_mst_seq
  import i2c_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              fifo_en_i,
  input  logic              stall_en_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_i,
  input  logic [CNT_W-1:0]  rx_cnt_i,
  input  logic              ack_i,
  input  logic              bus_busy_i,
  input  logic              ber_clr_i,
  input  logic              nack_clr_i,
  input  logic              stall_clr_i,
  input  logic              eob_clr_i,
  output logic              mode_o,
  output logic              xmit_o,
  output logic              data_rdy_o,
  output logic              ber_o,
  output logic              nack_o,
  output logic              stall_o,
  output logic              txe_o,
  output logic              busy_o,
  output logic              bb_o,
  output logic              eob_o,
  output logic              cmd_addr_o,
  output logic              cmd_tx_o,
  output logic              cmd_rx_o,
  output logic              cmd_end_o,
  output logic [DATA_W-1:0] cmd_byte_o
);
  logic [NFLAG-1:0] flag_set, flag_clr, flag_q;
  logic c_addr, c_tx, c_rx, c_end;

  i2c_seq_ctl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctl (
    .clk_i, .rst_ni, .en_i, .fifo_en_i, .stall_en_i, .start_i, .stop_i,
    .wr_i, .wr_data_i, .rd_i, .rx_cnt_i, .ack_i, .bus_busy_i,
    .ber_clr_i, .nack_clr_i, .stall_clr_i, .eob_clr_i,
    .mode_i   (flag_q[F_MODE]),
    .set_o    (flag_set),
    .clr_o    (flag_clr),
    .c_addr_o (c_addr),
    .c_tx_o   (c_tx),
    .c_rx_o   (c_rx),
    .c_end_o  (c_end)
  );

  i2c_seq_flags #(.N(NFLAG)) u_flags (
    .clk_i, .rst_ni,
    .set_i (flag_set),
    .clr_i (flag_clr),
    .q_o   (flag_q)
  );

  i2c_seq_cmd #(.DATA_W(DATA_W)) u_cmd (
    .clk_i, .rst_ni,
    .addr_i (c_addr),
    .tx_i   (c_tx),
    .rx_i   (c_rx),
    .end_i  (c_end),
    .byte_i (wr_data_i),
    .addr_o (cmd_addr_o),
    .tx_o   (cmd_tx_o),
    .rx_o   (cmd_rx_o),
    .end_o  (cmd_end_o),
    .byte_o (cmd_byte_o)
  );

  assign mode_o     = flag_q[F_MODE];
  assign xmit_o     = flag_q[F_XMIT];
  assign data_rdy_o = flag_q[F_RDY];
  assign ber_o      = flag_q[F_BER];
  assign nack_o     = flag_q[F_NACK];
  assign stall_o    = flag_q[F_STALL];
  assign txe_o      = flag_q[F_TXE];
  assign busy_o     = flag_q[F_BUSY];
  assign bb_o       = flag_q[F_BB];
  assign eob_o      = flag_q[F_EOB];

  // R1: at most one bus command per cycle
  a_r1_one_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_addr_o, cmd_tx_o, cmd_rx_o, cmd_end_o}));

  // R7: an end command leaves master state released
  a_r7_end_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_end_o && $past(!eob_clr_i) |-> !mode_o && !busy_o && !bb_o && eob_o);

  // R11: one disabled cycle wipes flags and commands
  a_r11_disable_wipes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!en_i) |-> !mode_o && !busy_o && !eob_o && !txe_o && !nack_o &&
                     !(cmd_addr_o | cmd_tx_o | cmd_rx_o | cmd_end_o));

  // R5: a fresh NACK never coexists with data ready
  a_r5_nack_drops_rdy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nack_o) |-> !data_rdy_o);

  // R3: a fresh bus error comes from a failed start
  a_r3_ber_not_master: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ber_o) |-> !mode_o && !busy_o && bb_o);
endmodule

// File: tb/i2c_mst_seq_tb.sv
module i2c_mst_seq_tb;
  localparam int OP_START = 0, OP_STOP = 1, OP_WR = 2, OP_RD = 3, OP_NCLR = 4,
                 OP_BCLR = 5, OP_SCLR = 6, OP_ECLR = 7, OP_DIS = 8, OP_NOP = 9;
  localparam int B_MODE = 0, B_XMIT = 1, B_RDY = 2, B_BER = 3, B_NACK = 4,
                 B_STALL = 5, B_TXE = 6, B_BUSY = 7, B_BB = 8, B_EOB = 9;
  localparam int P_IDLE = 0, P_SEND = 1, P_RECV = 2, P_NACK = 3, P_SRX = 4, P_SNK = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b1, fifo_en = 1'b0, stall_en = 1'b0, start = 1'b0, stop = 1'b0;
  logic wr = 1'b0, rd = 1'b0, ack = 1'b1, bus_busy = 1'b0;
  logic ber_clr = 1'b0, nack_clr = 1'b0, stall_clr = 1'b0, eob_clr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [4:0] rx_cnt = '0;
  logic mode, xmit, rdy, ber, nack, stall, txe, busy, bb, eob;
  logic c_addr, c_tx, c_rx, c_end;
  logic [7:0] c_byte;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [9:0] em = '0;
  logic [3:0] ec = '0;
  logic [7:0] eb = '0;
  int ph = P_IDLE;
  string mt;

  always #5 clk = ~clk;

  i2c_mst_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .fifo_en_i(fifo_en),
    .stall_en_i(stall_en), .start_i(start), .stop_i(stop), .wr_i(wr),
    .wr_data_i(wr_data), .rd_i(rd), .rx_cnt_i(rx_cnt), .ack_i(ack),
    .bus_busy_i(bus_busy), .ber_clr_i(ber_clr), .nack_clr_i(nack_clr),
    .stall_clr_i(stall_clr), .eob_clr_i(eob_clr),
    .mode_o(mode), .xmit_o(xmit), .data_rdy_o(rdy), .ber_o(ber),
    .nack_o(nack), .stall_o(stall), .txe_o(txe), .busy_o(busy), .bb_o(bb),
    .eob_o(eob), .cmd_addr_o(c_addr), .cmd_tx_o(c_tx), .cmd_rx_o(c_rx),
    .cmd_end_o(c_end), .cmd_byte_o(c_byte)
  );

  function automatic logic [9:0] act_flags();
    return {eob, bb, busy, txe, stall, nack, ber, rdy, xmit, mode};
  endfunction

  task automatic compare(input string tag);
    logic [9:0] af;
    logic [3:0] ac;
    af = act_flags();
    ac = {c_end, c_rx, c_tx, c_addr};
    n_chk++;
    if (af !== em || ac !== ec || ((ec[0] | ec[1]) && c_byte !== eb)) begin
      n_bad++;
      $display("FAIL %s: flags %b cmd %b byte %h, expected flags %b cmd %b byte %h",
               tag, af, ac, c_byte, em, ec, eb);
    end
  endtask

  task automatic m_end();
    em[B_MODE] = 0; em[B_XMIT] = 0; em[B_RDY] = 0; em[B_BER] = 0;
    em[B_NACK] = 0; em[B_STALL] = 0; em[B_BUSY] = 0; em[B_BB] = 0;
    em[B_EOB] = 1; ec[3] = 1; ph = P_IDLE;
  endtask

  // expected outcome of one strobe, from the requirements
  task automatic model(input int op, input logic [7:0] b, input bit a, input int cnt);
    ec = '0;
    mt = "R10";
    case (op)
      OP_DIS: begin em = '0; ph = P_IDLE; mt = "R11"; end
      OP_START: begin
        if (!bus_busy || ph != P_IDLE) begin
          em[B_MODE] = 1; em[B_XMIT] = 1; em[B_RDY] = 1; em[B_BUSY] = 1;
          if (fifo_en) em[B_TXE] = 1;
          mt = "R2";
        end else begin
          em[B_MODE] = 0; em[B_BUSY] = 0; em[B_BER] = 1; mt = "R3";
        end
        em[B_BB] = 1; ph = P_IDLE;
      end
      OP_STOP: if (em[B_MODE]) begin
        if (ph == P_RECV) begin ph = P_SRX; mt = "R8"; end
        else if (ph == P_NACK) begin ph = P_SNK; mt = "R9"; end
        else if (ph == P_SRX) mt = "R8";
        else if (ph == P_SNK) mt = "R9";
        else begin m_end(); mt = "R7"; end
      end
      OP_WR: if (em[B_MODE] && ph == P_IDLE) begin
        ec[0] = 1; eb = b; em[B_XMIT] = !b[0];
        if (!a) begin em[B_RDY] = 0; em[B_NACK] = 1; ph = P_NACK; mt = "R5"; end
        else begin
          em[B_NACK] = 0; ph = b[0] ? P_RECV : P_SEND;
          if (stall_en) begin em[B_STALL] = 1; mt = "R6"; end
          else begin em[B_RDY] = 1; mt = "R4"; end
          if (fifo_en && !b[0]) em[B_TXE] = 1;
        end
      end else if (em[B_MODE] && ph == P_SEND) begin
        ec[1] = 1; eb = b; mt = "R13";
        if (!a) begin em[B_RDY] = 0; em[B_NACK] = 1; ph = P_NACK; end
        else begin em[B_RDY] = 1; if (fifo_en) em[B_TXE] = 1; end
      end
      OP_RD: begin
        mt = "R14";
        if (ph == P_RECV) begin ec[2] = 1; em[B_RDY] = 1; end
        else if (ph == P_SRX) begin
          mt = "R8";
          if (!fifo_en || cnt <= 1) m_end();
        end
      end
      OP_NCLR: begin
        mt = "R12"; em[B_NACK] = 0;
        if (ph == P_SNK) begin m_end(); mt = "R9"; end
      end
      OP_BCLR: begin em[B_BER] = 0; mt = "R12"; end
      OP_SCLR: begin em[B_STALL] = 0; mt = "R12"; end
      OP_ECLR: begin em[B_EOB] = 0; mt = "R12"; end
      default: mt = "R1";
    endcase
  endtask

  // called at a negedge; checks at the following negedge
  task automatic do_op(input int op, input logic [7:0] b, input bit a, input int cnt,
                       input string tag);
    wr_data = b; ack = a; rx_cnt = cnt[4:0];
    case (op)
      OP_START: start = 1;
      OP_STOP:  stop = 1;
      OP_WR:    wr = 1;
      OP_RD:    rd = 1;
      OP_NCLR:  nack_clr = 1;
      OP_BCLR:  ber_clr = 1;
      OP_SCLR:  stall_clr = 1;
      OP_ECLR:  eob_clr = 1;
      OP_DIS:   en = 0;
      default: ;
    endcase
    model(op, b, a, cnt);
    @(negedge clk);
    start = 0; stop = 0; wr = 0; rd = 0; nack_clr = 0;
    ber_clr = 0; stall_clr = 0; eob_clr = 0; en = 1;
    compare({tag, "/", mt});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare("R1_reset");

    fifo_en = 1; bus_busy = 0;
    do_op(OP_START, 8'h00, 1, 0, "R2_start_idle_bus");
    do_op(OP_WR, 8'hA1, 1, 0, "R4_addr_read_ack");
    do_op(OP_WR, 8'h33, 1, 0, "R10_write_while_recv");
    do_op(OP_RD, 8'h00, 1, 0, "R14_read_fetch");
    do_op(OP_STOP, 8'h00, 1, 0, "R8_stop_deferred");
    do_op(OP_RD, 8'h00, 1, 3, "R8_fifo_cnt3_holds");
    do_op(OP_RD, 8'h00, 1, 1, "R8_fifo_cnt1_ends");
    do_op(OP_ECLR, 8'h00, 1, 0, "R12_eob_clear");
    do_op(OP_WR, 8'h5A, 1, 0, "R10_write_not_master");
    do_op(OP_STOP, 8'h00, 1, 0, "R10_stop_not_master");
    bus_busy = 1;
    do_op(OP_START, 8'h00, 1, 0, "R3_start_busy_fails");
    do_op(OP_BCLR, 8'h00, 1, 0, "R12_ber_clear");
    bus_busy = 0; fifo_en = 0;
    do_op(OP_START, 8'h00, 1, 0, "R2_start_nofifo");
    do_op(OP_WR, 8'h50, 0, 0, "R5_addr_nack");
    do_op(OP_WR, 8'h11, 1, 0, "R10_write_in_nack");
    do_op(OP_STOP, 8'h00, 1, 0, "R9_stop_deferred");
    do_op(OP_NOP, 8'h00, 1, 0, "R9_still_pending");
    do_op(OP_NCLR, 8'h00, 1, 0, "R9_nack_clear_ends");
    do_op(OP_START, 8'h00, 1, 0, "R2_start_again");
    stall_en = 1;
    do_op(OP_WR, 8'h42, 1, 0, "R6_stall_on_ack");
    do_op(OP_SCLR, 8'h00, 1, 0, "R12_stall_clear");
    stall_en = 0; fifo_en = 1;
    do_op(OP_WR, 8'hC3, 1, 0, "R13_send_ack");
    bus_busy = 1;
    do_op(OP_START, 8'h00, 1, 0, "R2_repeated_start_busy");
    bus_busy = 0;
    do_op(OP_WR, 8'h64, 1, 0, "R4_addr_write_ack");
    do_op(OP_WR, 8'h99, 0, 0, "R13_send_nack");
    do_op(OP_START, 8'h00, 1, 0, "R2_start_from_nack");
    do_op(OP_WR, 8'h20, 1, 0, "R4_addr_write");
    do_op(OP_STOP, 8'h00, 1, 0, "R7_stop_in_send");
    do_op(OP_START, 8'h00, 1, 0, "R2_start_pre_dis");
    do_op(OP_WR, 8'hA3, 1, 0, "R4_addr_read");
    do_op(OP_DIS, 8'h00, 1, 0, "R11_disable");
    fifo_en = 0;
    do_op(OP_START, 8'h00, 1, 0, "R2_start_rx_nofifo");
    do_op(OP_WR, 8'hA5, 1, 0, "R4_addr_read_nofifo");
    do_op(OP_STOP, 8'h00, 1, 0, "R8_stop_deferred_nofifo");
    do_op(OP_RD, 8'h00, 1, 5, "R8_nofifo_read_ends");

    for (int i = 0; i < 1500; i++) begin
      int r, op;
      if ($urandom % 16 == 0) fifo_en = 1'($urandom);
      if ($urandom % 16 == 0) stall_en = 1'($urandom);
      if ($urandom % 8 == 0) bus_busy = 1'($urandom);
      r = $urandom % 100;
      if (r < 12) op = OP_START;
      else if (r < 22) op = OP_STOP;
      else if (r < 45) op = OP_WR;
      else if (r < 62) op = OP_RD;
      else if (r < 70) op = OP_NCLR;
      else if (r < 75) op = OP_BCLR;
      else if (r < 79) op = OP_SCLR;
      else if (r < 83) op = OP_ECLR;
      else if (r < 85) op = OP_DIS;
      else op = OP_NOP;
      do_op(op, 8'($urandom), ($urandom % 4) != 0, $urandom % 4, "rnd");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule